// File: doc/BRIEF.md
# Hierarchical Leading Non-Zero Detector

This block streams the non-zero entries of an activation vector to a single broadcast point, in ascending global index order, skipping every zero entry. The vector is interleaved over `N_LEAF` leaf slices. Global index `g` lives in leaf `g mod N_LEAF` at local slot `g / N_LEAF`. Each leaf keeps its slice in a small loadable register array. It offers its lowest-indexed non-zero entry as a candidate, tagged with that entry's global index.

A four-ary tree of registered selection nodes reduces the candidates. With 64 leaves there are 16, then 4, then 1 node. Each node forwards the child candidate with the lowest global index. The controller at the root presents the winner as a broadcast with a valid/ready handshake. When the broadcast is accepted, the controller tells the owning leaf to clear that entry. It then waits for the change to travel up the registered tree before it presents the next candidate. When no non-zero entry remains and the tree has settled, it raises `done`.

The vector is written one entry per cycle through a load port, addressed by global index. A load may arrive at any time. It restarts the settling wait, so the next broadcast reflects the updated contents.

Top module: `lnzd_tree`

## Requirements
- R1: While reset is applied, `bcast_valid` and `done` are low. After reset, with nothing loaded, `done` goes high and no broadcast ever appears.
- R2: Only non-zero entries are broadcast. `bcast_val` is never zero while `bcast_valid` is high, and each loaded non-zero entry is broadcast exactly once.
- R3: Between loads, successive accepted broadcasts carry strictly increasing `bcast_idx`, and the presented entry is always the lowest-indexed non-zero entry still held.
- R4: A load with address `a` and data `d` stores `d` at global index `a`, which is held in leaf `a mod N_LEAF` at local slot `a / N_LEAF`. The entry is later broadcast with `bcast_idx` equal to `a` and `bcast_val` equal to `d`, for every index from 0 to N_LEAF*DEPTH-1.
- R5: A broadcast is accepted on a clock edge where `bcast_valid` and `bcast_ready` are both high. While `bcast_ready` is low and no load occurs, `bcast_valid`, `bcast_idx` and `bcast_val` hold steady.
- R6: After an accepted broadcast or a load, `bcast_valid` and `done` stay low for LVLS cycles, where LVLS = log4(N_LEAF) = 3 by default. The next broadcast, or `done`, appears in the LVLS+1-th cycle.
- R7: `done` is high exactly when the tree has settled and no non-zero entry remains. `done` and `bcast_valid` are never high together, and `done` stays high until the next load.
- R8: A load issued while a broadcast is pending replaces the pending candidate if its index is lower. Writing zero over a pending non-zero entry removes that entry from the stream.
- R9: A second load to the same index overwrites the first, and only the latest value is broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_en | input | 1 | Write one activation entry this cycle |
| ld_addr | input | IW | Global index of the entry written |
| ld_data | input | DW | Activation value written (zero clears the entry) |
| bcast_ready | input | 1 | Downstream accepts the presented broadcast |
| bcast_valid | output | 1 | A non-zero activation is presented |
| bcast_idx | output | IW | Global index of the presented activation |
| bcast_val | output | DW | Value of the presented activation |
| done | output | 1 | No non-zero activation remains |

## Verification
The drain is exercised with an empty vector, with single entries at the lowest and highest index, with a fully populated vector, and with several random sparse vectors that include zero-valued loads. These patterns separate a correct ascending scan from a scan that drops, repeats or reorders entries, or that emits zero entries. Entries that share a leaf show whether a leaf advances past its popped slot. Random back-pressure on `bcast_ready` shows whether held broadcasts stay stable and whether the next broadcast appears exactly LVLS+1 cycles after an acceptance. Directed overwrites, including one with a lower index arriving during a stall and one writing zero over a pending entry, test that loads re-arm the tree.

// File: rtl/lnzd_pkg.sv
package lnzd_pkg;

  // Start position of tree level l inside the flat candidate array.
  // Level 0 holds the n leaves; each higher level holds a quarter as many.
  function automatic int lvl_off(int n, int l);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s += n >> (2 * i);
    return s;
  endfunction

  // Number of four-way levels needed to reduce n leaves to one.
  function automatic int log4(int n);
    int k;
    int v;
    k = 0;
    v = 1;
    while (v < n) begin
      v = v * 4;
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/lnzd_leaf.sv
module lnzd_leaf #(
  parameter int N_LEAF = 64,
  parameter int DEPTH  = 4,
  parameter int DW     = 16,
  parameter int IW     = 8,
  parameter int ID     = 0,
  localparam int CW    = 1 + IW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          pop_en,
  input  logic [IW-1:0] pop_idx,
  output logic [CW-1:0] cand
);
  localparam int LOG_N = $clog2(N_LEAF);
  localparam logic [LOG_N-1:0] MY_ID = LOG_N'(ID);

  logic [DW-1:0] act_q [DEPTH];
  logic [DW-1:0] act_d [DEPTH];
  logic          ld_hit;
  logic          pop_hit;
  logic          upd_en;
  logic [IW-LOG_N-1:0] ld_pos;
  logic [IW-LOG_N-1:0] pop_pos;

  assign ld_hit  = ld_en  && (ld_addr[LOG_N-1:0] == MY_ID);
  assign pop_hit = pop_en && (pop_idx[LOG_N-1:0] == MY_ID);
  assign ld_pos  = ld_addr[IW-1:LOG_N];
  assign pop_pos = pop_idx[IW-1:LOG_N];
  assign upd_en  = ld_hit || pop_hit;

  // Next-state: a pop clears its slot, a load written in the same cycle wins.
  always_comb begin
    act_d = act_q;
    if (pop_hit) act_d[pop_pos] = '0;
    if (ld_hit)  act_d[ld_pos]  = ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) act_q[i] <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
    end
  end

  // Lowest local slot holding a non-zero value; scanned downward so the
  // last assignment belongs to the lowest slot.
  always_comb begin
    cand = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (act_q[j] != '0) cand = {1'b1, IW'(j * N_LEAF + ID), act_q[j]};
    end
  end

endmodule

// File: rtl/lnzd_node.sv
module lnzd_node #(
  parameter int DW  = 16,
  parameter int IW  = 8,
  localparam int CW = 1 + IW + DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0][CW-1:0]  kids,
  output logic [CW-1:0]       win
);
  logic [CW-1:0] best;

  always_comb begin
    best = kids[0];
    for (int i = 1; i < 4; i++) begin
      if (kids[i][CW-1] &&
          (!best[CW-1] || (kids[i][CW-2:DW] < best[CW-2:DW]))) begin
        best = kids[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= best;
  end

endmodule

// File: rtl/lnzd_ctrl.sv
module lnzd_ctrl #(
  parameter int DW   = 16,
  parameter int IW   = 8,
  parameter int LVLS = 3,
  localparam int CW  = 1 + IW + DW,
  localparam int WCW = $clog2(LVLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] root,
  input  logic          ld_en,
  input  logic          bcast_ready,
  output logic          bcast_valid,
  output logic [IW-1:0] bcast_idx,
  output logic [DW-1:0] bcast_val,
  output logic          done,
  output logic          pop_en
);
  localparam logic [WCW-1:0] SETTLE = WCW'(LVLS);

  logic [WCW-1:0] wait_q;
  logic [WCW-1:0] wait_d;
  logic           settled;
  logic           fire;

  assign settled     = (wait_q == '0);
  assign bcast_valid = settled && root[CW-1];
  assign done        = settled && !root[CW-1];
  assign bcast_idx   = root[CW-2:DW];
  assign bcast_val   = root[DW-1:0];
  assign fire        = bcast_valid && bcast_ready;
  assign pop_en      = fire;

  // Any change to leaf contents needs LVLS edges to reach the root register.
  always_comb begin
    wait_d = wait_q;
    if (fire || ld_en)   wait_d = SETTLE;
    else if (!settled)   wait_d = wait_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= SETTLE;
    else        wait_q <= wait_d;
  end

endmodule

// File: rtl/lnzd_tree.sv
module lnzd_tree #(
  parameter int N_LEAF = 64,
  parameter int DEPTH  = 4,
  parameter int DW     = 16,
  localparam int IW    = $clog2(N_LEAF) + $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          bcast_ready,
  output logic          bcast_valid,
  output logic [IW-1:0] bcast_idx,
  output logic [DW-1:0] bcast_val,
  output logic          done
);
  import lnzd_pkg::*;

  localparam int LVLS = log4(N_LEAF);
  localparam int CW   = 1 + IW + DW;
  localparam int TOT  = lvl_off(N_LEAF, LVLS + 1);
  localparam int ROOT = TOT - 1;

  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  logic [TOT-1:0][CW-1:0] cand;
  logic                 pop_en;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
    lnzd_leaf #(
      .N_LEAF(N_LEAF), .DEPTH(DEPTH), .DW(DW), .IW(IW), .ID(k)
    ) u_leaf (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .pop_en  (pop_en),
      .pop_idx (bcast_idx),
      .cand    (cand[k])
    );
  end

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    localparam int CNT = N_LEAF >> (2 * l);
    localparam int IB  = lvl_off(N_LEAF, l - 1);
    localparam int OB  = lvl_off(N_LEAF, l);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      lnzd_node #(.DW(DW), .IW(IW)) u_node (
        .clk   (clk),
        .rst_n (rst_core_n),
        .kids  (cand[IB + 4 * j +: 4]),
        .win   (cand[OB + j])
      );
    end
  end

  lnzd_ctrl #(.DW(DW), .IW(IW), .LVLS(LVLS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .root        (cand[ROOT]),
    .ld_en       (ld_en),
    .bcast_ready (bcast_ready),
    .bcast_valid (bcast_valid),
    .bcast_idx   (bcast_idx),
    .bcast_val   (bcast_val),
    .done        (done),
    .pop_en      (pop_en)
  );

endmodule

// File: rtl/lnzd_tree_chk.sv
module lnzd_tree_chk #(
  parameter int DW = 16,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_en,
  input logic          bcast_ready,
  input logic          bcast_valid,
  input logic [IW-1:0] bcast_idx,
  input logic [DW-1:0] bcast_val,
  input logic          done
);
  logic          have_last;
  logic [IW-1:0] last_idx;
  logic          fire;

  assign fire = bcast_valid && bcast_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_idx  <= '0;
    end else if (ld_en) begin
      have_last <= 1'b0;
    end else if (fire) begin
      have_last <= 1'b1;
      last_idx  <= bcast_idx;
    end
  end

  a_r2_nonzero_only: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> (bcast_val != '0));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_last && !ld_en) |-> (bcast_idx > last_idx));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_valid && !bcast_ready && !ld_en) |=>
      (bcast_valid && $stable(bcast_idx) && $stable(bcast_val)));

  a_r6_gap_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!bcast_valid && !done));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && bcast_valid));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ld_en) |=> done);

endmodule

bind lnzd_tree lnzd_tree_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_en       (ld_en),
  .bcast_ready (bcast_ready),
  .bcast_valid (bcast_valid),
  .bcast_idx   (bcast_idx),
  .bcast_val   (bcast_val),
  .done        (done)
);

// File: tb/lnzd_tree_test.sv
module lnzd_tree_test;
  localparam int N_LEAF = 64;
  localparam int DEPTH  = 4;
  localparam int DW     = 16;
  localparam int IW     = 8;
  localparam int TOTAL  = N_LEAF * DEPTH;
  localparam int LVLS   = 3;

  logic          clk;
  logic          rst_n;
  logic          ld_en;
  logic [IW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic          bcast_ready;
  logic          bcast_valid;
  logic [IW-1:0] bcast_idx;
  logic [DW-1:0] bcast_val;
  logic          done;

  int n_chk;
  int n_bad;
  logic [DW-1:0] model [TOTAL];

  lnzd_tree #(.N_LEAF(N_LEAF), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .bcast_ready(bcast_ready), .bcast_valid(bcast_valid),
    .bcast_idx(bcast_idx), .bcast_val(bcast_val), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_nz();
    for (int i = 0; i < TOTAL; i++) if (model[i] != '0) return i;
    return -1;
  endfunction

  task automatic load(input int a, input int d);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_addr = IW'(a);
    ld_data = DW'(d);
    model[a] = DW'(d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drain every remaining entry, ready high with probability rdy_pct percent.
  task automatic drain(input int rdy_pct);
    int  since;
    bit  fired;
    bit  prev_valid;
    int  e;
    bit  r;
    since = 0;
    fired = 1'b0;
    prev_valid = 1'b0;
    bcast_ready = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      since++;
      if (bcast_valid) begin
        e = lowest_nz();
        chk(e >= 0, "R2", int'(bcast_idx), e);
        chk(int'(bcast_idx) == e, "R3", int'(bcast_idx), e);
        if (e >= 0) chk(bcast_val == model[e], "R4", int'(bcast_val), int'(model[e]));
        chk(bcast_val != '0, "R2", int'(bcast_val), 1);
        chk(!done, "R7", int'(done), 0);
        if (fired && !prev_valid) chk(since == LVLS + 1, "R6", since, LVLS + 1);
      end
      if (done) begin
        chk(lowest_nz() == -1, "R7", lowest_nz(), -1);
        if (fired) chk(since == LVLS + 1, "R6", since, LVLS + 1);
        bcast_ready = 1'b0;
        return;
      end
      r = (($urandom % 100) < rdy_pct);
      if (bcast_valid && r) begin
        model[bcast_idx] = '0;
        since = 0;
        fired = 1'b1;
      end
      prev_valid  = bcast_valid && !r;
      bcast_ready = r;
    end
    chk(1'b0, "R7", 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0;
    n_bad = 0;
    for (int i = 0; i < TOTAL; i++) model[i] = '0;
    rst_n = 1'b0;
    ld_en = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    bcast_ready = 1'b0;
    wait_cyc(3);
    // R1: quiet in reset
    chk(!bcast_valid, "R1", int'(bcast_valid), 0);
    chk(!done, "R1", int'(done), 0);
    rst_n = 1'b1;
    wait_cyc(10);
    chk(done, "R1", int'(done), 1);
    chk(!bcast_valid, "R1", int'(bcast_valid), 0);
    drain(100);

    // R4: extreme indices
    load(0, 16'h0011);
    load(TOTAL - 1, 16'hBEEF);
    drain(100);

    // R9: overwrite keeps latest
    load(10, 1);
    load(10, 77);
    drain(60);

    // R8: zero over a pending entry removes it
    load(42, 5);
    wait_cyc(6);
    chk(bcast_valid && bcast_idx == 8'd42, "R8", int'(bcast_idx), 42);
    load(42, 0);
    wait_cyc(6);
    chk(done && !bcast_valid, "R8", int'(done), 1);

    // R8: lower index arriving during a stall takes over; R5 hold
    load(200, 5);
    wait_cyc(6);
    chk(bcast_valid && bcast_idx == 8'd200, "R5", int'(bcast_idx), 200);
    wait_cyc(5);
    chk(bcast_valid && bcast_idx == 8'd200 && bcast_val == 16'd5, "R5", int'(bcast_val), 5);
    load(3, 9);
    wait_cyc(6);
    chk(bcast_valid && bcast_idx == 8'd3 && bcast_val == 16'd9, "R8", int'(bcast_idx), 3);
    drain(100);

    // R3: several entries in one leaf (leaf 5)
    for (int s = 0; s < DEPTH; s++) load(5 + s * N_LEAF, 100 + s);
    drain(50);

    // Fully populated vector
    for (int i = 0; i < TOTAL; i++) load(i, i + 1);
    drain(100);

    // Random sparse vectors with back-pressure, zero loads included
    for (int round = 0; round < 6; round++) begin
      for (int i = 0; i < 60; i++) begin
        int a;
        int d;
        a = int'($urandom % TOTAL);
        d = (($urandom % 4) == 0) ? 0 : int'($urandom % 65536);
        load(a, d);
      end
      drain(40 + round * 10);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule